// File: doc/BRIEF.md
# Bit-Plane Reshaping Buffer for Bit-Serial In-Memory Compute

This block sits between a 32-bit system bus and the row drivers of a bit-serial compute array. Software writes packed input-vector elements, four 8-bit lanes per bus word, into a small bank of element registers. Once the vector is complete, the buffer replays it one bit-plane per handshake, most significant plane first. In each plane, output bit i is the selected bit of element i. The array therefore sees a single bit per element in each compute cycle. A plane index tells the downstream accumulator which binary weight applies to the plane.

The element precision is programmable from 1 to 8 bits. A zero flag marks planes whose bits are all 0, so a sparsity controller can skip array activity for those planes. A complementary line is driven for signed (±1, XNOR) products. In unsigned (AND) mode that line is parked low.

After a vector has been replayed, an advance command rotates the stored elements circularly by a programmable stride and replays them. This lets overlapping convolution windows be reused without fetching the data again.

The controller has three states:
- ST_LOAD: accepts words until the vector is full, then moves to ST_EMIT.
- ST_EMIT: issues planes. After the plane with index 0 is taken, it moves to ST_HOLD.
- ST_HOLD: waits. An advance moves it to ST_EMIT and rotates the elements. Otherwise an accepted word moves it to ST_LOAD and is written to the first slot.

Top module: `bitplane_reshaper`

## Requirements
- R1: After reset the buffer is in the load state: `pln_valid` is 0 and `wr_ready` is 1.
- R2: A bus word carries four elements. Element 4·w+k of the vector is taken from bits [8k+7:8k] of the w-th accepted word. Once the fourth word is accepted, `pln_valid` rises in the next cycle. `wr_ready` stays 0 for as long as planes are being issued.
- R3: The precision field `cfg_prec` (legal values 1..8) and the mode input are sampled when issuing begins. For precision p, exactly p planes are issued, with `pln_idx` running p-1, p-2, …, 0. `pln_last` is 1 only on index 0. Changing the configuration during issue has no effect.
- R4: In a plane with index b, bit i of `pln_bits` equals bit b of element i. Element bits at positions p and above never appear.
- R5: While `pln_valid` is 1 and `pln_ready` is 0, the plane outputs stay unchanged and `pln_valid` stays 1.
- R6: `pln_zero` is 1 exactly when every bit of the current plane is 0.
- R7: With `cfg_and_mode` = 0 (XNOR), `pln_bits_n` is the bitwise complement of `pln_bits`. With `cfg_and_mode` = 1 (AND), `pln_bits_n` is all 0.
- R8: After the last plane is taken, `pln_valid` is 0 and the buffer holds. A one-cycle `adv` pulse in that state rotates the elements, so that new element i = old element (i + `cfg_stride`) mod 16. The rotated vector is then replayed. A stride of 0 replays the same contents.
- R9: In the hold state, `adv` takes priority over a write: `wr_ready` is 0 while `adv` is 1. A word accepted without `adv` starts a new load, and that word fills elements 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prec | input | 4 | Element precision in bits, 1..8 |
| cfg_and_mode | input | 1 | 1 selects unsigned AND products, 0 selects XNOR |
| cfg_stride | input | 4 | Rotation amount in elements, applied on advance |
| wr_valid | input | 1 | Bus word is offered |
| wr_ready | output | 1 | Buffer accepts the offered word |
| wr_data | input | 32 | Four packed 8-bit elements |
| adv | input | 1 | Rotate by the stride and replay (hold state only) |
| pln_valid | output | 1 | A bit-plane is presented |
| pln_ready | input | 1 | Array takes the plane |
| pln_bits | output | 16 | One bit per element for the current plane |
| pln_bits_n | output | 16 | Complementary row lines (XNOR) or parked low (AND) |
| pln_idx | output | 3 | Bit weight of the current plane |
| pln_zero | output | 1 | Current plane has no set bit |
| pln_last | output | 1 | Current plane is the least significant one |

## Verification
The assertions assume that `cfg_prec` holds a value from 1 to 8 whenever issue begins. They also assume that `adv` is raised only while the buffer holds, because an advance in any other state is ignored. The stimulus writes the configuration before the last word or the advance that starts an issue, and issues `adv` only after every expected plane has been taken. The ready line to the array follows a fixed pattern that leaves one cycle in three low, so stall cycles happen in the middle of replays.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_EMIT = 2'd1,
        ST_HOLD = 2'd2
    } rsb_state_e;
endpackage

// File: rtl/rsb_store.sv
module rsb_store #(
    parameter int N       = 16,
    parameter int ELEM_W  = 8,
    parameter int LANES   = 4,
    parameter int SLOT_W  = 2,
    parameter int SHIFT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SLOT_W-1:0]         wr_slot,
    input  logic [LANES*ELEM_W-1:0]   wr_data,
    input  logic                      rot_en,
    input  logic [SHIFT_W-1:0]        rot_amt,
    output logic [N*ELEM_W-1:0]       elems_o
);
    logic [ELEM_W-1:0] mem_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem_q[i] <= '0;
        end else if (rot_en) begin
            for (int i = 0; i < N; i++) mem_q[i] <= mem_q[(i + int'(rot_amt)) % N];
        end else if (wr_en) begin
            for (int i = 0; i < N; i++)
                if (i / LANES == int'(wr_slot))
                    mem_q[i] <= wr_data[(i % LANES)*ELEM_W +: ELEM_W];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign elems_o[g*ELEM_W +: ELEM_W] = mem_q[g];
    end

    AST_NO_ROT_AND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rot_en && wr_en)); // R9
endmodule

// File: rtl/rsb_plane_select.sv
module rsb_plane_select #(
    parameter int N      = 16,
    parameter int ELEM_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [N*ELEM_W-1:0] elems,
    input  logic [IDX_W-1:0]    idx,
    input  logic                and_mode,
    output logic [N-1:0]        bits,
    output logic [N-1:0]        bits_n,
    output logic                zero
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [ELEM_W-1:0] e;
        assign e       = elems[g*ELEM_W +: ELEM_W];
        assign bits[g] = e[idx];
    end

    assign bits_n = and_mode ? '0 : ~bits;
    assign zero   = ~|bits;
endmodule

// File: rtl/bitplane_reshaper.sv
module bitplane_reshaper #(
    parameter int NUM_BANKS  = 8,
    parameter int BANK_DEPTH = 2,
    parameter int ELEM_W     = 8,
    parameter int WORD_W     = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [$clog2(ELEM_W):0]               cfg_prec,
    input  logic                                  cfg_and_mode,
    input  logic [$clog2(NUM_BANKS*BANK_DEPTH)-1:0] cfg_stride,
    input  logic                                  wr_valid,
    output logic                                  wr_ready,
    input  logic [WORD_W-1:0]                     wr_data,
    input  logic                                  adv,
    output logic                                  pln_valid,
    input  logic                                  pln_ready,
    output logic [NUM_BANKS*BANK_DEPTH-1:0]       pln_bits,
    output logic [NUM_BANKS*BANK_DEPTH-1:0]       pln_bits_n,
    output logic [$clog2(ELEM_W)-1:0]             pln_idx,
    output logic                                  pln_zero,
    output logic                                  pln_last
);
    import rsb_pkg::*;

    localparam int N          = NUM_BANKS * BANK_DEPTH;
    localparam int LANES      = WORD_W / ELEM_W;
    localparam int LOAD_WORDS = N / LANES;
    localparam int SLOT_W     = (LOAD_WORDS > 1) ? $clog2(LOAD_WORDS) : 1;
    localparam int IDX_W      = $clog2(ELEM_W);
    localparam int PREC_W     = IDX_W + 1;
    localparam int SHIFT_W    = $clog2(N);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LOAD_WORDS - 1);

    rsb_state_e        state_q, state_d;
    logic [SLOT_W-1:0] wcnt_q, wcnt_d;
    logic [IDX_W-1:0]  plane_q, plane_d;
    logic              mode_q, mode_d;
    logic              wr_fire, pl_fire, rot_en, start;
    logic [SLOT_W-1:0] wr_slot;
    logic [N*ELEM_W-1:0] elems;

    // Output process: handshakes and store controls
    always_comb begin
        wr_ready  = 1'b0;
        pln_valid = 1'b0;
        rot_en    = 1'b0;
        wr_slot   = wcnt_q;
        unique case (state_q)
            ST_LOAD: wr_ready = 1'b1;
            ST_EMIT: pln_valid = 1'b1;
            ST_HOLD: begin
                wr_ready = !adv;
                rot_en   = adv;
                wr_slot  = '0;
            end
            default: ;
        endcase
    end

    assign wr_fire  = wr_valid && wr_ready;
    assign pl_fire  = pln_valid && pln_ready;
    assign pln_idx  = plane_q;
    assign pln_last = pln_valid && (plane_q == '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        start   = 1'b0;
        unique case (state_q)
            ST_LOAD: if (wr_fire) begin
                if (wcnt_q == LAST_SLOT) begin
                    wcnt_d  = '0;
                    start   = 1'b1;
                    state_d = ST_EMIT;
                end else begin
                    wcnt_d = wcnt_q + 1'b1;
                end
            end
            ST_EMIT: if (pl_fire && plane_q == '0) state_d = ST_HOLD;
            ST_HOLD: begin
                if (adv) begin
                    start   = 1'b1;
                    state_d = ST_EMIT;
                end else if (wr_fire) begin
                    wcnt_d  = SLOT_W'(1);
                    state_d = ST_LOAD;
                end
            end
            default: state_d = ST_LOAD;
        endcase
        plane_d = plane_q;
        mode_d  = mode_q;
        if (start) begin
            plane_d = IDX_W'(cfg_prec - PREC_W'(1));
            mode_d  = cfg_and_mode;
        end else if (pl_fire && plane_q != '0) begin
            plane_d = plane_q - 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            wcnt_q  <= '0;
            plane_q <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            plane_q <= plane_d;
            mode_q  <= mode_d;
        end
    end

    rsb_store #(
        .N(N), .ELEM_W(ELEM_W), .LANES(LANES), .SLOT_W(SLOT_W), .SHIFT_W(SHIFT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_slot(wr_slot),
        .wr_data(wr_data), .rot_en(rot_en), .rot_amt(cfg_stride), .elems_o(elems)
    );

    rsb_plane_select #(
        .N(N), .ELEM_W(ELEM_W), .IDX_W(IDX_W)
    ) u_sel (
        .elems(elems), .idx(plane_q), .and_mode(mode_q),
        .bits(pln_bits), .bits_n(pln_bits_n), .zero(pln_zero)
    );

    AST_LOAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        pln_valid |-> !wr_ready); // R2
    AST_FIRST_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pln_valid) |-> pln_idx == IDX_W'($past(cfg_prec) - PREC_W'(1))); // R3
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pln_valid && pln_ready && !pln_last) |=> pln_valid && (pln_idx == $past(pln_idx) - 1'b1)); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pln_valid && !pln_ready) |=> pln_valid && $stable(pln_idx) && $stable(pln_bits)); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pln_valid && pln_zero) |-> $countones(pln_bits) == 0); // R6
    AST_AND_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pln_valid && mode_q) |-> pln_bits_n == '0); // R7
    AST_LAST_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pln_valid && pln_ready && pln_last) |=> !pln_valid); // R8
    AST_ADV_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && adv) |-> !wr_ready); // R9
endmodule

// File: tb/test_bitplane_reshaper.sv
module test_bitplane_reshaper;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  cfg_prec = 4'd8;
    logic        cfg_and_mode = 1'b0;
    logic [3:0]  cfg_stride = 4'd0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic        adv = 1'b0;
    logic        pln_valid;
    logic        pln_ready = 1'b0;
    logic [N-1:0] pln_bits, pln_bits_n;
    logic [2:0]  pln_idx;
    logic        pln_zero, pln_last;

    always #5 clk = ~clk;

    bitplane_reshaper i_bitplane_reshaper (
        .clk(clk), .rst_n(rst_n), .cfg_prec(cfg_prec), .cfg_and_mode(cfg_and_mode),
        .cfg_stride(cfg_stride), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .adv(adv), .pln_valid(pln_valid), .pln_ready(pln_ready),
        .pln_bits(pln_bits), .pln_bits_n(pln_bits_n), .pln_idx(pln_idx),
        .pln_zero(pln_zero), .pln_last(pln_last)
    );

    typedef struct {
        logic [N-1:0] bits;
        logic [2:0]   idx;
        logic         zero;
        logic         last;
        logic         andm;
    } plane_t;

    plane_t exp_q[$];
    logic [7:0] mdl [N];
    logic [7:0] nv  [N];
    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_planes(input int p, input bit andm);
        for (int b = p - 1; b >= 0; b--) begin
            plane_t e;
            for (int i = 0; i < N; i++) e.bits[i] = mdl[i][b];
            e.idx  = 3'(b);
            e.zero = (e.bits == '0);
            e.last = (b == 0);
            e.andm = andm;
            exp_q.push_back(e);
        end
    endtask

    task automatic put_word(input logic [31:0] d);
        @(posedge clk); #1;
        wr_valid = 1'b1;
        wr_data  = d;
        forever begin
            @(negedge clk);
            if (wr_ready) break;
        end
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    // R2 R9: load nv as four packed words, elements 4w+k in byte lane k
    task automatic load_vec(input int p, input bit andm);
        cfg_prec = 4'(p);
        cfg_and_mode = andm;
        for (int i = 0; i < N; i++) mdl[i] = nv[i];
        push_planes(p, andm);
        for (int w = 0; w < 4; w++)
            put_word({nv[4*w+3], nv[4*w+2], nv[4*w+1], nv[4*w]});
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(posedge clk);
        @(posedge clk); #1;
        repeat (2) begin
            @(negedge clk);
            chk(pln_valid == 1'b0, "R8 idle after last plane", 32'(pln_valid), 0);
        end
    endtask

    // R8: rotate model by stride, replay; optional competing write (R9)
    task automatic advance(input int s, input int p, input bit andm, input bit with_wr);
        logic [7:0] tmp [N];
        cfg_stride = 4'(s);
        cfg_prec = 4'(p);
        cfg_and_mode = andm;
        for (int i = 0; i < N; i++) tmp[i] = mdl[(i + s) % N];
        for (int i = 0; i < N; i++) mdl[i] = tmp[i];
        push_planes(p, andm);
        @(posedge clk); #1;
        adv = 1'b1;
        if (with_wr) begin
            wr_valid = 1'b1;
            wr_data  = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        if (with_wr) chk(wr_ready == 1'b0, "R9 advance beats write", 32'(wr_ready), 0);
        @(posedge clk); #1;
        adv = 1'b0;
        wr_valid = 1'b0;
        // R3: configuration changes after issue starts must not matter
        cfg_prec = 4'd8;
        cfg_and_mode = ~andm;
    endtask

    // ready pattern: low one cycle in three
    int cyc = 0;
    always @(posedge clk) begin
        #1;
        cyc++;
        pln_ready = (cyc % 3) != 1;
    end

    // monitor
    plane_t held;
    bit     stalled = 1'b0;
    always @(negedge clk) begin
        if (rst_n && pln_valid) begin
            chk(wr_ready == 1'b0, "R2 no write while issuing", 32'(wr_ready), 0);
            if (stalled) begin
                chk(pln_bits == held.bits && pln_idx == held.idx, "R5 stall keeps plane",
                    {13'd0, pln_idx, pln_bits}, {13'd0, held.idx, held.bits});
            end
            held.bits = pln_bits;
            held.idx  = pln_idx;
            stalled   = !pln_ready;
            if (pln_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected plane", 32'(pln_idx), 0);
                end else begin
                    plane_t e;
                    e = exp_q.pop_front();
                    chk(pln_idx == e.idx, "R3 plane index", 32'(pln_idx), 32'(e.idx));
                    chk(pln_last == e.last, "R3 last flag", 32'(pln_last), 32'(e.last));
                    chk(pln_bits == e.bits, "R4 plane bits", 32'(pln_bits), 32'(e.bits));
                    chk(pln_zero == e.zero, "R6 zero flag", 32'(pln_zero), 32'(e.zero));
                    chk(pln_bits_n == (e.andm ? '0 : ~e.bits), "R7 complement line",
                        32'(pln_bits_n), 32'(e.andm ? '0 : ~e.bits));
                end
            end
        end else begin
            stalled = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(pln_valid == 1'b0, "R1 reset valid", 32'(pln_valid), 0);
        chk(wr_ready == 1'b1, "R1 reset ready", 32'(wr_ready), 1);

        // R2 R4: full precision, XNOR
        for (int i = 0; i < N; i++) nv[i] = 8'(i * 17 + 3);
        load_vec(8, 1'b0);
        drain();

        // R4 R6 R7: 4-bit AND, upper bits set, plane 2 all zero
        for (int i = 0; i < N; i++) nv[i] = 8'hF0 | ((i % 2) ? 8'h0B : 8'h09);
        load_vec(4, 1'b1);
        drain();

        // R8: rotate by 3 then by 0, then by 15 at 1-bit precision
        for (int i = 0; i < N; i++) nv[i] = 8'(i * 29 + 7);
        load_vec(3, 1'b1);
        drain();
        advance(3, 3, 1'b1, 1'b0);
        drain();
        advance(0, 2, 1'b0, 1'b0);
        drain();
        advance(15, 1, 1'b0, 1'b0);
        drain();

        // R9: advance with competing write, then reload from slot 0
        advance(5, 5, 1'b0, 1'b1);
        drain();
        for (int i = 0; i < N; i++) nv[i] = 8'(8'hFE & 8'(i * 3));
        load_vec(1, 1'b0);
        drain();
        for (int i = 0; i < N; i++) nv[i] = 8'(i);
        load_vec(5, 1'b0);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule